// File: doc/BRIEF.md
# Set/Clear Output Port

This block drives a port of general-purpose pins from a small memory-mapped register bus. Software never overwrites the output latch as a whole. It raises pins by writing ones to a set register and lowers them by writing ones to a clear register. Bits written as zero leave their pins alone, so independent pieces of software can own different pins without a read-modify-write.

A direction register chooses which pins are driven. A pin with its direction bit at 1 drives its latch value, and its enable is high. A pin with its direction bit at 0 is released to high impedance: its enable is low and its data output is held at 0. The bus carries one strobe per byte lane. The set and clear registers can therefore be written as full words, as half-words or as single bytes, and a narrow write reaches only the pins of its enabled lanes. A byte or half-word write uses the byte address of its lane inside the register word.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset the output latch, the direction register, every pad enable and every pad data output are 0.
- R2: A write to byte offset 0x00 updates the direction register in the lanes whose strobe is high, and a read of 0x00 returns it. A direction bit of 1 makes the pin an output.
- R3: A write to the set register at word offset 0x18 forces to 1 every latch bit written as 1, and leaves bits written as 0 unchanged.
- R4: A write to the clear register at word offset 0x1C forces to 0 every latch bit written as 1, and leaves bits written as 0 unchanged.
- R5: A byte write to clear with only strobe k high (byte address 0x1C+k) clears only pins 8k to 8k+7, whatever the other lanes of the write data hold.
- R6: A half-word clear with strobes 0b0011 (address 0x1C) touches only pins 0 to 15, and one with strobes 0b1100 (address 0x1E) touches only pins 16 to 31.
- R7: The set register has the same byte and half-word lane layout at 0x18, 0x19, 0x1A, 0x1B.
- R8: Consecutive set and clear writes to the same bit leave the value of the latest write. A clear, set, clear sequence on one pin gives low, then a one-write-long high pulse, then low.
- R9: A read of byte offset 0x14 returns the output latch, and a write there has no effect. Reads of the set and clear registers return 0.
- R10: Each pad enable equals its direction bit. Each pad data output equals the latch bit where the pin is an output and 0 where it is an input.
- R11: A write with all lane strobes low, or a transfer without the select, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| bus_sel | input | 1 | Transfer select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address inside the block |
| bus_be | input | 4 | Byte-lane strobes, bit k for data bits 8k+7:8k |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pad_out | output | 32 | Pin data outputs |
| pad_oe | output | 32 | Pin output enables (0 = high impedance) |

## Verification
The bench goes after narrow clear and set writes whose unselected lanes carry ones. A design that ignored the strobes would wipe or raise pins in neighbouring bytes. It repeats a clear, set, clear sequence on one pin. A design that merged the writes, or let set win over an older clear, would miss the pulse or end high. It writes to the read-only latch offset and issues a write with no strobes; a decoder that aliased these would corrupt the latch. It checks input pins for data leaking onto pad_out, and that reads of the write-only registers return zero instead of latch contents.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  // byte offsets of the register words
  localparam int unsigned OFS_DIR = 32'h00;
  localparam int unsigned OFS_OUT = 32'h14;
  localparam int unsigned OFS_SET = 32'h18;
  localparam int unsigned OFS_CLR = 32'h1C;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_DIR,
    TGT_OUT,
    TGT_SET,
    TGT_CLR
  } gpio_tgt_e;
endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
  import gpio_sc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  output gpio_tgt_e         tgt,
  output logic [DATA_W-1:0] lane_mask,
  output logic              dir_we,
  output logic              set_we,
  output logic              clr_we
);
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] W_DIR = WIDX_W'(OFS_DIR >> 2);
  localparam logic [WIDX_W-1:0] W_OUT = WIDX_W'(OFS_OUT >> 2);
  localparam logic [WIDX_W-1:0] W_SET = WIDX_W'(OFS_SET >> 2);
  localparam logic [WIDX_W-1:0] W_CLR = WIDX_W'(OFS_CLR >> 2);

  logic [WIDX_W-1:0] widx;
  logic              unused_lo;
  logic              wr_any;

  assign widx      = bus_addr[ADDR_W-1:2];
  // lane choice comes from the strobes, not the low address bits
  assign unused_lo = ^bus_addr[1:0];
  assign wr_any    = bus_sel && bus_wr && (|bus_be);

  always_comb begin
    tgt = TGT_NONE;
    if (bus_sel) begin
      if      (widx == W_DIR) tgt = TGT_DIR;
      else if (widx == W_OUT) tgt = TGT_OUT;
      else if (widx == W_SET) tgt = TGT_SET;
      else if (widx == W_CLR) tgt = TGT_CLR;
    end
  end

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lane_mask[8*k +: 8] = {8{bus_be[k]}};
    end
  endgenerate

  assign dir_we = wr_any && (tgt == TGT_DIR);
  assign set_we = wr_any && (tgt == TGT_SET);
  assign clr_we = wr_any && (tgt == TGT_CLR);
endmodule

// File: rtl/gpio_sc_dir.sv
module gpio_sc_dir #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dir
);
  logic [DATA_W-1:0] dir_d;
  logic [DATA_W-1:0] dir_q;

  always_comb begin
    dir_d = (dir_q & ~mask) | (wdata & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (we) begin
      dir_q <= dir_d;
    end
  end

  assign dir = dir_q;

  // R2: lanes written take the data, no write keeps the value
  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((dir_q & $past(mask)) == ($past(wdata) & $past(mask))));
  a_r11_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(dir_q));
endmodule

// File: rtl/gpio_sc_latch.sv
module gpio_sc_latch #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_mask,
  input  logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_d;
  logic [DATA_W-1:0] q_r;
  logic              upd;

  always_comb begin
    upd = (|set_mask) || (|clr_mask);
    // clear wins if both ever reach one bit together
    q_d = (q_r | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (upd) begin
      q_r <= q_d;
    end
  end

  assign q = q_r;

  a_r3_set_bits_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((|set_mask) && !(|clr_mask)) |=> ((q_r & $past(set_mask)) == $past(set_mask)));
  a_r4_clr_bits_low: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((q_r & $past(clr_mask)) == '0));
  a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|set_mask) && !(|clr_mask)) |=> $stable(q_r));
  a_r3_untouched_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask || |clr_mask) |=>
      ((q_r & ~($past(set_mask) | $past(clr_mask))) ==
       ($past(q_r) & ~($past(set_mask) | $past(clr_mask)))));
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gpio_sc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [DATA_W-1:0]   pad_out,
  output logic [DATA_W-1:0]   pad_oe
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  gpio_tgt_e         tgt;
  logic [DATA_W-1:0] lane_mask;
  logic              dir_we;
  logic              set_we;
  logic              clr_we;
  logic [DATA_W-1:0] set_mask;
  logic [DATA_W-1:0] clr_mask;
  logic [DATA_W-1:0] dir;
  logic [DATA_W-1:0] latch;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  gpio_sc_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .tgt       (tgt),
    .lane_mask (lane_mask),
    .dir_we    (dir_we),
    .set_we    (set_we),
    .clr_we    (clr_we)
  );

  always_comb begin
    set_mask = set_we ? (bus_wdata & lane_mask) : '0;
    clr_mask = clr_we ? (bus_wdata & lane_mask) : '0;
  end

  gpio_sc_dir #(.DATA_W(DATA_W)) u_dir (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (dir_we),
    .mask  (lane_mask),
    .wdata (bus_wdata),
    .dir   (dir)
  );

  gpio_sc_latch #(.DATA_W(DATA_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .q        (latch)
  );

  always_comb begin
    unique case (tgt)
      TGT_DIR: bus_rdata = dir;
      TGT_OUT: bus_rdata = latch;
      default: bus_rdata = '0;
    endcase
  end

  assign pad_oe  = dir;
  assign pad_out = latch & dir;

  a_r10_no_drive_on_input: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((pad_out & ~pad_oe) == '0));
  a_r9_write_only_read_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((tgt == TGT_SET) || (tgt == TGT_CLR)) |-> (bus_rdata == '0));
  a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({dir_we, set_we, clr_we}));
endmodule

// File: tb/test_gpio_setclr_port.sv
module test_gpio_setclr_port;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int checks;
  int failures;

  // {addr, strobes, data, expected latch afterwards}
  localparam logic [75:0] VEC [NVEC] = '{
    {8'h18, 4'hF, 32'hFFFF0000, 32'hFFFF0000},  // R3 word set
    {8'h18, 4'hF, 32'h000000F0, 32'hFFFF00F0},  // R3
    {8'h1C, 4'hF, 32'h0F000010, 32'hF0FF00E0},  // R4 word clear
    {8'h18, 4'hF, 32'h0000FF00, 32'hF0FFFFE0},  // R3
    {8'h1D, 4'h2, 32'hFFFF5AFF, 32'hF0FFA5E0},  // R5 lane 1
    {8'h1F, 4'h8, 32'h30FFFFFF, 32'hC0FFA5E0},  // R5 lane 3
    {8'h1C, 4'h1, 32'hFFFFFF20, 32'hC0FFA5C0},  // R5 lane 0
    {8'h1E, 4'h4, 32'hFF81FFFF, 32'hC07EA5C0},  // R5 lane 2
    {8'h1C, 4'h3, 32'hFFFF0FF0, 32'hC07EA000},  // R6 lower half
    {8'h1E, 4'hC, 32'h4006FFFF, 32'h8078A000},  // R6 upper half
    {8'h19, 4'h2, 32'hFFFF0FFF, 32'h8078AF00},  // R7 set byte
    {8'h1A, 4'hC, 32'h0003FFFF, 32'h807BAF00},  // R7 set half
    {8'h14, 4'hF, 32'hFFFFFFFF, 32'h807BAF00},  // R9 latch offset read-only
    {8'h1C, 4'h0, 32'hFFFFFFFF, 32'h807BAF00}   // R11 no strobes
  };

  gpio_setclr_port i_gpio_setclr_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d,
                           input logic sel = 1'b1);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'h0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = 4'hF;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0; bus_be = 4'h0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    checks = 0; failures = 0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_read(8'h14, rd); check("R1 latch", rd, 32'h0);
    bus_read(8'h00, rd); check("R1 dir", rd, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);

    // main table
    for (int i = 0; i < NVEC; i++) begin
      bus_write(VEC[i][75:68], VEC[i][67:64], VEC[i][63:32]);
      bus_read(8'h14, rd);
      check($sformatf("R3-7/R9/R11 vector %0d", i), rd, VEC[i][31:0]);
    end

    // R11 unselected write
    bus_write(8'h1C, 4'hF, 32'hFFFFFFFF, 1'b0);
    bus_read(8'h14, rd); check("R11 unselected", rd, 32'h807BAF00);

    // R9 write-only registers read zero
    bus_read(8'h18, rd); check("R9 set reads 0", rd, 32'h0);
    bus_read(8'h1C, rd); check("R9 clr reads 0", rd, 32'h0);

    // R2 direction with byte strobes, R10 pads
    bus_write(8'h00, 4'hF, 32'h0000FFFF);
    bus_write(8'h02, 4'h4, 32'hFF0F0000);
    bus_read(8'h00, rd); check("R2 dir readback", rd, 32'h000FFFFF);
    check("R10 pad_oe", pad_oe, 32'h000FFFFF);
    check("R10 pad_out masked", pad_out, 32'h807BAF00 & 32'h000FFFFF);

    // R8 clear, set, clear pulse on pin 7
    bus_write(8'h1C, 4'h1, 32'h00000080);
    check("R8 low after clear", {31'b0, pad_out[7]}, 32'h0);
    bus_write(8'h18, 4'h1, 32'h00000080);
    check("R8 high after set", {31'b0, pad_out[7]}, 32'h1);
    bus_write(8'h1C, 4'h1, 32'h00000080);
    check("R8 low after final clear", {31'b0, pad_out[7]}, 32'h0);

    // R10 pin turned to input releases data
    bus_write(8'h18, 4'hF, 32'h00F00000);
    check("R10 input pin undriven", pad_out & 32'h00F00000, 32'h00000000);
    bus_read(8'h14, rd); check("R10 latch still holds", rd & 32'h00F00000, 32'h00F00000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule